// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps the precision time for a packet time-stamping unit. Time is held as a 32-bit seconds count and a 32-bit nanoseconds count, clocked by a dedicated reference clock. On every clock edge the nanoseconds count grows by a programmable step of 0 to 255 ns. When the sum reaches one billion, the nanoseconds count wraps and the seconds count rises by one on the same edge.

Capture logic reads the combined 64-bit value from a single output bus. Software-facing logic sets the step through a write strobe with a data byte. It sets the time directly through an initialise strobe that carries both the seconds and the nanoseconds values. The step must be large enough for the clock rate: at the 255 ns maximum, the reference clock must run at about 4 MHz or faster for the time to advance one second per real second.

Top module: `ptp_time_counter`

## Requirements
- R1: A synchronous active-high reset clears seconds, nanoseconds and the step register to zero. After reset is released and before any step is written, the time does not move.
- R2: On each clock edge without initialise and without wrap, nanoseconds becomes its previous value plus the step register, and seconds is unchanged.
- R3: The step is an 8-bit unsigned value, so 255 ns is the largest per-edge advance. As long as the value loaded by initialise is below 1,000,000,000, nanoseconds never reaches 1,000,000,000.
- R4: When nanoseconds plus the step is 1,000,000,000 or more, nanoseconds becomes that sum minus 1,000,000,000 and seconds increments by one on the same edge.
- R5: When the initialise strobe is high at an edge, seconds and nanoseconds take the supplied values exactly on that edge, and the step is not added.
- R6: The step register takes a written byte on the edge where the write strobe is high. That edge still advances time by the old step, and the new step is first added on the following edge.
- R7: With a step of zero, the time holds its value on every edge without initialise.
- R8: The time output carries nanoseconds in bits 31:0 and seconds in bits 63:32.
- R9: When seconds is 4,294,967,295 and nanoseconds wraps, seconds rolls over to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that paces the time |
| rst | input | 1 | Synchronous active-high reset |
| inc_wr | input | 1 | Write strobe for the step register |
| inc_data | input | 8 | New step in nanoseconds per edge |
| init_en | input | 1 | Strobe to load seconds and nanoseconds |
| init_sec | input | 32 | Seconds value to load |
| init_ns | input | 32 | Nanoseconds value to load (below one billion) |
| time_out | output | 64 | Current time, seconds high and nanoseconds low |

## Verification
The hardest cases to reach are the wrap boundaries, because counting up to one billion nanoseconds from reset would take millions of edges. The bench uses the initialise strobe to place nanoseconds a few steps below the limit. From there it checks an exact landing on zero, a wrap with the maximum 255 ns step, and a wrap while seconds is all ones. It also checks the one-edge latency of a step write by writing a new step while the old one is still non-zero and then counting the advances on the edges that follow.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

  localparam int unsigned PTP_NS_W_DEF    = 32;
  localparam int unsigned PTP_SEC_W_DEF   = 32;
  localparam int unsigned PTP_INC_W_DEF   = 8;
  localparam int unsigned PTP_NS_LIMIT_DEF = 1000000000;

  // What the counter does on a given edge; brought out for the checker.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_WRAP = 2'd2,
    ACT_LOAD = 2'd3
  } ptp_act_e;

endpackage

// File: rtl/ptp_inc_reg.sv
module ptp_inc_reg #(
  parameter int unsigned INC_W = ptp_time_pkg::PTP_INC_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [INC_W-1:0] din,
  output logic [INC_W-1:0] inc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0;
    end else if (wr) begin
      inc_q <= din;
    end
  end

endmodule

// File: rtl/ptp_ns_accum.sv
module ptp_ns_accum #(
  parameter int unsigned NS_W     = ptp_time_pkg::PTP_NS_W_DEF,
  parameter int unsigned INC_W    = ptp_time_pkg::PTP_INC_W_DEF,
  parameter int unsigned NS_LIMIT = ptp_time_pkg::PTP_NS_LIMIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NS_W-1:0]  load_ns,
  input  logic [INC_W-1:0] inc,
  output logic [NS_W-1:0]  ns_q,
  output logic             wrap
);

  localparam int unsigned SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(NS_LIMIT);

  // Raw sum with one spare bit so the compare never overflows.
  function automatic logic [SUM_W-1:0] ns_sum(input logic [NS_W-1:0] ns,
                                              input logic [INC_W-1:0] step);
    return {1'b0, ns} + SUM_W'(step);
  endfunction

  function automatic logic sum_wraps(input logic [SUM_W-1:0] s);
    return s >= LIMIT_V;
  endfunction

  function automatic logic [NS_W-1:0] fold(input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] r;
    r = sum_wraps(s) ? (s - LIMIT_V) : s;
    return r[NS_W-1:0];
  endfunction

  logic [SUM_W-1:0] sum;
  logic [NS_W-1:0]  ns_next;

  always_comb begin
    sum     = ns_sum(ns_q, inc);
    wrap    = sum_wraps(sum) && !load;
    ns_next = load ? load_ns : fold(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q <= '0;
    end else begin
      ns_q <= ns_next;
    end
  end

endmodule

// File: rtl/ptp_sec_count.sv
module ptp_sec_count #(
  parameter int unsigned SEC_W = ptp_time_pkg::PTP_SEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic             bump,
  output logic [SEC_W-1:0] sec_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
    end else if (load) begin
      sec_q <= load_sec;
    end else if (bump) begin
      sec_q <= sec_q + SEC_W'(1);
    end
  end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int unsigned NS_W     = ptp_time_pkg::PTP_NS_W_DEF,
  parameter int unsigned SEC_W    = ptp_time_pkg::PTP_SEC_W_DEF,
  parameter int unsigned INC_W    = ptp_time_pkg::PTP_INC_W_DEF,
  parameter int unsigned NS_LIMIT = ptp_time_pkg::PTP_NS_LIMIT_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc_wr,
  input  logic [INC_W-1:0]      inc_data,
  input  logic                  init_en,
  input  logic [SEC_W-1:0]      init_sec,
  input  logic [NS_W-1:0]       init_ns,
  output logic [SEC_W+NS_W-1:0] time_out
);

  import ptp_time_pkg::*;

  logic [INC_W-1:0] inc_q;
  logic [NS_W-1:0]  ns_q;
  logic [SEC_W-1:0] sec_q;
  logic             ns_wrap;
  ptp_act_e         act;

  ptp_inc_reg #(.INC_W(INC_W)) inc_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (inc_wr),
    .din   (inc_data),
    .inc_q (inc_q)
  );

  ptp_ns_accum #(.NS_W(NS_W), .INC_W(INC_W), .NS_LIMIT(NS_LIMIT)) ns_i (
    .clk     (clk),
    .rst     (rst),
    .load    (init_en),
    .load_ns (init_ns),
    .inc     (inc_q),
    .ns_q    (ns_q),
    .wrap    (ns_wrap)
  );

  ptp_sec_count #(.SEC_W(SEC_W)) sec_i (
    .clk      (clk),
    .rst      (rst),
    .load     (init_en),
    .load_sec (init_sec),
    .bump     (ns_wrap),
    .sec_q    (sec_q)
  );

  // Named edge action for observation by the checker.
  always_comb begin
    if (init_en)             act = ACT_LOAD;
    else if (ns_wrap)        act = ACT_WRAP;
    else if (inc_q != '0)    act = ACT_STEP;
    else                     act = ACT_HOLD;
  end

  assign time_out = {sec_q, ns_q};

endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
  parameter int unsigned NS_W     = 32,
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned INC_W    = 8,
  parameter int unsigned NS_LIMIT = 1000000000
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inc_wr,
  input logic [INC_W-1:0]      inc_data,
  input logic                  init_en,
  input logic [SEC_W-1:0]      init_sec,
  input logic [NS_W-1:0]       init_ns,
  input logic [SEC_W+NS_W-1:0] time_out,
  input logic [INC_W-1:0]      inc_q,
  input logic                  ns_wrap,
  input ptp_time_pkg::ptp_act_e act
);

  logic [NS_W-1:0]  ns_v;
  logic [SEC_W-1:0] sec_v;
  assign ns_v  = time_out[NS_W-1:0];
  assign sec_v = time_out[SEC_W+NS_W-1:NS_W];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (time_out == '0) && (inc_q == '0));

  assert_plain_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init_en) && !$past(ns_wrap))
      |-> (ns_v == $past(ns_v) + NS_W'($past(inc_q))) && (sec_v == $past(sec_v)));

  assert_ns_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init_en) && ($past(ns_v) < NS_W'(NS_LIMIT)))
      |-> (ns_v < NS_W'(NS_LIMIT)));

  assert_wrap_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act) == ptp_time_pkg::ACT_WRAP)
      |-> (sec_v == $past(sec_v) + SEC_W'(1)));

  assert_init_load_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(init_en)) |-> (time_out == {$past(init_sec), $past(init_ns)}));

  assert_inc_write_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inc_wr)) |-> (inc_q == $past(inc_data)));

  assert_zero_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init_en) && $past(inc_q) == '0) |-> $stable(time_out));

endmodule

bind ptp_time_counter ptp_time_counter_chk #(
  .NS_W(NS_W), .SEC_W(SEC_W), .INC_W(INC_W), .NS_LIMIT(NS_LIMIT)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inc_wr   (inc_wr),
  .inc_data (inc_data),
  .init_en  (init_en),
  .init_sec (init_sec),
  .init_ns  (init_ns),
  .time_out (time_out),
  .inc_q    (inc_q),
  .ns_wrap  (ns_wrap),
  .act      (act)
);

// File: tb/ptp_time_counter_tb_top.sv
module ptp_time_counter_tb_top;

  localparam int unsigned BILLION = 1000000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_wr = 1'b0;
  logic [7:0]  inc_data = '0;
  logic        init_en = 1'b0;
  logic [31:0] init_sec = '0;
  logic [31:0] init_ns = '0;
  logic [63:0] time_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ptp_time_counter dut_i (
    .clk      (clk),
    .rst      (rst),
    .inc_wr   (inc_wr),
    .inc_data (inc_data),
    .init_en  (init_en),
    .init_sec (init_sec),
    .init_ns  (init_ns),
    .time_out (time_out)
  );

  // Expected layout per R8: seconds high, nanoseconds low.
  function automatic logic [63:0] mk(input longint unsigned s, input longint unsigned n);
    logic [31:0] s32;
    logic [31:0] n32;
    s32 = s[31:0];
    n32 = n[31:0];
    return {s32, n32};
  endfunction

  task automatic chk(input string req, input logic [63:0] exp);
    checks++;
    if (time_out !== exp) begin
      errors++;
      $display("FAIL %s: actual sec=%0d ns=%0d expected sec=%0d ns=%0d",
               req, time_out[63:32], time_out[31:0], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_inc(input logic [7:0] v);
    inc_wr = 1'b1; inc_data = v;
    @(negedge clk);
    inc_wr = 1'b0;
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] n);
    init_en = 1'b1; init_sec = s; init_ns = n;
    @(negedge clk);
    init_en = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R1 reset value", mk(0, 0));
    chk("R8 zero layout", mk(0, 0));
    tick(4);
    chk("R1 no motion before step write", mk(0, 0));
  endtask

  task automatic t_inc_latency;
    write_inc(8);
    chk("R6 write edge uses old step", mk(0, 0));
    tick(1);
    chk("R6 new step on next edge", mk(0, 8));
    tick(4);
    chk("R2 steady advance", mk(0, 40));
  endtask

  task automatic t_init_priority;
    load(7, 1000);
    chk("R5 init wins over step", mk(7, 1000));
    tick(2);
    chk("R2 advance after init", mk(7, 1016));
  endtask

  task automatic t_wrap_exact;
    load(7, BILLION - 16);
    tick(1);
    chk("R2 below limit", mk(7, BILLION - 8));
    tick(1);
    chk("R4 exact landing on zero", mk(8, 0));
    tick(1);
    chk("R2 after wrap", mk(8, 8));
  endtask

  task automatic t_wrap_max;
    write_inc(255);
    chk("R6 write edge still adds old step", mk(8, 16));
    load(3, BILLION - 254);
    tick(1);
    chk("R4 wrap with max step", mk(4, 1));
    load(3, BILLION - 256);
    tick(1);
    chk("R3 max step stays below limit", mk(3, BILLION - 1));
    tick(1);
    chk("R4 wrap remainder", mk(4, 254));
  endtask

  task automatic t_sec_rollover;
    load(32'hFFFF_FFFF, BILLION - 255);
    chk("R8 all-ones seconds layout", mk(32'hFFFF_FFFF, BILLION - 255));
    tick(1);
    chk("R9 seconds roll over", mk(0, 0));
  endtask

  task automatic t_freeze;
    write_inc(0);
    chk("R6 zero write edge adds old 255", mk(0, 255));
    tick(6);
    chk("R7 zero step freezes time", mk(0, 255));
  endtask

  task automatic t_long_run;
    write_inc(1);
    tick(3);
    chk("R2 unit step", mk(0, 258));
    write_inc(200);
    chk("R6 edge with old unit step", mk(0, 259));
    tick(1000);
    chk("R2 long run", mk(0, 259 + 200 * 1000));
  endtask

  task automatic t_reset_mid;
    load(9, 12345);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk("R1 reset mid run", mk(0, 0));
    tick(3);
    chk("R1 step cleared by reset", mk(0, 0));
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset_state();
    t_inc_latency();
    t_init_priority();
    t_wrap_exact();
    t_wrap_max();
    t_sec_rollover();
    t_freeze();
    t_long_run();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule